// File: doc/BRIEF.md
# Rotating-priority interrupt resolver

This block holds the state of eight interrupt lines: which have been requested, which are masked, and which are currently being serviced. From that state it decides, every cycle, whether its single interrupt output should be raised. Priority is not fixed. The search starts at a rotating base line and wraps around all eight lines. A request raises the output only when it strictly outranks the best line already in service.

A separate command decoder drives the block. That decoder supplies the trigger-mode and mask writes, the mode bits and the end-of-interrupt commands. The processor side pulses an acknowledge strobe. During that strobe the block presents an 8-bit vector made of a programmed upper field and the winning line number, and at the end of the cycle it updates its service state. Two instances can be chained. When the instance marked as master acknowledges its cascade line, it hands the acknowledge to the second instance and returns that instance's vector.

Top module: `irq_resolver`

## Requirements
- R1: After reset, and after any later reset, the request, mask and in-service registers are clear, every line is edge-triggered and the rotate base is 0. The interrupt output is low.
- R2: An edge-triggered line sets its request bit at the clock edge where it is sampled high after having been sampled low. A line held high does not request again after its request has been taken.
- R3: A level-triggered line (trigger-mode bit 1) has a request bit that follows the sampled line level. The request bit is not cleared by an acknowledge.
- R4: A trigger-mode write changes only the bits set in TRIG_WMASK. All other bits keep their value.
- R5: The search gives level k to line (k + base) mod 8, and level 0 ranks highest. Pending requests are the request bits with no mask bit set. int_out is high exactly when the best pending level is strictly smaller than the best in-service level.
- R6: While ack is high and int_out is high, ack_vec equals {vec_base, winning line}. At that edge the winner's in-service bit is set, unless auto-EOI is on, and its request bit is cleared if the line is edge-triggered. int_out reflects the new state in the next cycle.
- R7: An ack while int_out is low returns {vec_base, 3'b111} and changes neither the in-service bits nor the rotate base.
- R8: In auto-EOI mode an acknowledge sets no in-service bit. If rotate-on-auto-EOI is also on, the rotate base becomes (winner + 1) mod 8.
- R9: cmd_op is applied when cmd_valid is high and no acknowledge with a winner is taken in that cycle. The codes are:
  - 1: clear the highest-ranked in-service bit.
  - 2: as code 1, and also set the base to that line + 1.
  - 3: clear the in-service bit of cmd_lvl.
  - 4: as code 3, and also set the base to cmd_lvl + 1.
  - 5: set the base to cmd_lvl + 1 only.
  - Other codes do nothing.
- R10: With special_mask set, in-service bits whose mask bit is set are ignored when the in-service level is computed.
- R11: With fully_nested and is_master both set, in-service bit 2 is ignored when the in-service level is computed.
- R12: On a master (is_master high), acknowledging line 2 raises casc_ack during the strobe and makes ack_vec equal casc_vec_in. The in-service update follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| trig_wr | input | 1 | Trigger-mode write strobe |
| trig_wdata | input | 8 | Trigger-mode write data, 1 = level-triggered |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data, 1 = masked |
| vec_base | input | 5 | Upper five bits of the acknowledge vector |
| is_master | input | 1 | Instance is the cascade master |
| auto_eoi | input | 1 | Acknowledge does not set in-service bits |
| rot_aeoi | input | 1 | Rotate base on acknowledge in auto-EOI mode |
| special_mask | input | 1 | Special-mask rule for the in-service level |
| fully_nested | input | 1 | Ignore the cascade line's in-service bit on a master |
| cmd_valid | input | 1 | End-of-interrupt / priority command strobe |
| cmd_op | input | 3 | Command code (see R9) |
| cmd_lvl | input | 3 | Line number for specific commands |
| ack | input | 1 | Acknowledge strobe |
| casc_vec_in | input | 8 | Vector supplied by the cascaded instance |
| ack_vec | output | 8 | Vector returned during ack |
| int_out | output | 1 | Interrupt request output |
| casc_ack | output | 1 | Acknowledge passed to the cascaded instance |

## Verification
The bench builds the block with TRIG_WMASK = 8'hF0. Lines 4 to 7 can therefore be turned level-triggered, while a write of all ones leaves lines 0 to 3 edge-triggered, and the checks see both halves. With a nonzero vector field, each returned vector shows both the field and the line number. The master strap and the mode bits are changed while the block runs, so rotation, auto-EOI, special mask, fully nested and cascade forwarding are each reached from a known in-service state.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned LINES     = 8;
  localparam int unsigned IDX_W     = $clog2(LINES);
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned BASE_W    = VEC_W - IDX_W;
  localparam int unsigned CASC_LINE = 2;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_EOI      = 3'd1,
    OP_EOI_ROT  = 3'd2,
    OP_SEOI     = 3'd3,
    OP_SEOI_ROT = 3'd4,
    OP_SETPRI   = 3'd5
  } eoi_op_e;

  // Level of the first set bit, searching from line 'base' and wrapping.
  // Returns LINES when no bit is set.
  function automatic logic [IDX_W:0] prio_scan(input logic [LINES-1:0] req,
                                               input logic [IDX_W-1:0] base);
    logic [IDX_W:0] lvl;
    logic           hit;
    lvl = (IDX_W+1)'(LINES);
    hit = 1'b0;
    for (int k = 0; k < LINES; k++) begin
      if (!hit && req[IDX_W'(k) + base]) begin
        lvl = (IDX_W+1)'(k);
        hit = 1'b1;
      end
    end
    return lvl;
  endfunction
endpackage

// File: rtl/irq_capture.sv
`timescale 1ns/1ps
module irq_capture import irq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] trig,
  input  logic [LINES-1:0] clr_edge,
  output logic [LINES-1:0] irr_q
);
  logic [LINES-1:0] last_q, last_d, irr_d, rise;

  always_comb begin
    rise   = irq_in & ~last_q & ~trig;
    last_d = irq_in;
    irr_d  = (irr_q & ~(clr_edge & ~trig)) | rise;
    irr_d  = (irr_d & ~trig) | (irq_in & trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      irr_q  <= '0;
    end else begin
      last_q <= last_d;
      irr_q  <= irr_d;
    end
  end

  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_in & ~last_q & ~trig)) |=>
      ((irr_q & $past(irq_in & ~last_q & ~trig)) == $past(irq_in & ~last_q & ~trig)));

  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> (((irr_q ^ $past(irq_in)) & $past(trig)) == '0));
endmodule

// File: rtl/irq_resolve.sv
`timescale 1ns/1ps
module irq_resolve import irq_pkg::*; (
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] imr,
  input  logic [LINES-1:0] isr,
  input  logic [IDX_W-1:0] base,
  input  logic             special_mask,
  input  logic             fully_nested,
  input  logic             is_master,
  output logic             fire,
  output logic [IDX_W-1:0] win
);
  logic [LINES-1:0] pend, isr_eff;
  logic [IDX_W:0]   p_lvl, c_lvl;

  always_comb begin
    pend    = irr & ~imr;
    isr_eff = isr;
    if (special_mask)             isr_eff = isr_eff & ~imr;
    if (fully_nested && is_master) isr_eff[CASC_LINE] = 1'b0;
    p_lvl = prio_scan(pend, base);
    c_lvl = prio_scan(isr_eff, base);
    fire  = (p_lvl < c_lvl);
    win   = p_lvl[IDX_W-1:0] + base;
  end
endmodule

// File: rtl/irq_service.sv
`timescale 1ns/1ps
module irq_service import irq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_fire,
  input  logic [IDX_W-1:0] win,
  input  logic             auto_eoi,
  input  logic             rot_aeoi,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_lvl,
  output logic [LINES-1:0] isr_q,
  output logic [IDX_W-1:0] base_q
);
  logic [LINES-1:0] isr_d;
  logic [IDX_W-1:0] base_d, ns_idx;
  logic [IDX_W:0]   ns_lvl;
  logic             upd;

  always_comb begin
    isr_d  = isr_q;
    base_d = base_q;
    ns_lvl = prio_scan(isr_q, base_q);
    ns_idx = ns_lvl[IDX_W-1:0] + base_q;
    upd    = ack_fire | cmd_valid;
    if (ack_fire) begin
      if (auto_eoi) begin
        if (rot_aeoi) base_d = win + 1'b1;
      end else begin
        isr_d[win] = 1'b1;
      end
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_EOI: begin
          if (!ns_lvl[IDX_W]) isr_d[ns_idx] = 1'b0;
        end
        OP_EOI_ROT: begin
          if (!ns_lvl[IDX_W]) begin
            isr_d[ns_idx] = 1'b0;
            base_d        = ns_idx + 1'b1;
          end
        end
        OP_SEOI:     isr_d[cmd_lvl] = 1'b0;
        OP_SEOI_ROT: begin
          isr_d[cmd_lvl] = 1'b0;
          base_d         = cmd_lvl + 1'b1;
        end
        OP_SETPRI:   base_d = cmd_lvl + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
    end else if (upd) begin
      isr_q  <= isr_d;
      base_q <= base_d;
    end
  end

  p_ack_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !auto_eoi) |=> isr_q[$past(win)]);

  p_aeoi_rot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && auto_eoi && rot_aeoi) |=> (base_q == IDX_W'($past(win) + 1'b1)));

  p_seoi_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ack_fire && (cmd_op == OP_SEOI)) |=> !isr_q[$past(cmd_lvl)]);
endmodule

// File: rtl/irq_resolver.sv
`timescale 1ns/1ps
module irq_resolver import irq_pkg::*; #(
  parameter logic [LINES-1:0] TRIG_WMASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              trig_wr,
  input  logic [LINES-1:0]  trig_wdata,
  input  logic              mask_wr,
  input  logic [LINES-1:0]  mask_wdata,
  input  logic [BASE_W-1:0] vec_base,
  input  logic              is_master,
  input  logic              auto_eoi,
  input  logic              rot_aeoi,
  input  logic              special_mask,
  input  logic              fully_nested,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_lvl,
  input  logic              ack,
  input  logic [VEC_W-1:0]  casc_vec_in,
  output logic [VEC_W-1:0]  ack_vec,
  output logic              int_out,
  output logic              casc_ack
);
  logic [1:0]       rs_q;
  logic             rst_ni;
  logic [LINES-1:0] trig_q, trig_d, imr_q, imr_d, irr_w, isr_w, clr_edge;
  logic [IDX_W-1:0] base_w, win;
  logic             fire, ack_fire, casc_hit;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  always_comb begin
    trig_d = trig_q;
    imr_d  = imr_q;
    if (trig_wr) trig_d = (trig_q & ~TRIG_WMASK) | (trig_wdata & TRIG_WMASK);
    if (mask_wr) imr_d  = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      imr_q  <= '0;
    end else begin
      if (trig_wr) trig_q <= trig_d;
      if (mask_wr) imr_q  <= imr_d;
    end
  end

  assign ack_fire = ack & fire;
  assign clr_edge = ack_fire ? (LINES'(1) << win) : '0;

  irq_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_ni),
    .irq_in   (irq_in),
    .trig     (trig_q),
    .clr_edge (clr_edge),
    .irr_q    (irr_w)
  );

  irq_resolve u_res (
    .irr          (irr_w),
    .imr          (imr_q),
    .isr          (isr_w),
    .base         (base_w),
    .special_mask (special_mask),
    .fully_nested (fully_nested),
    .is_master    (is_master),
    .fire         (fire),
    .win          (win)
  );

  irq_service u_svc (
    .clk       (clk),
    .rst_n     (rst_ni),
    .ack_fire  (ack_fire),
    .win       (win),
    .auto_eoi  (auto_eoi),
    .rot_aeoi  (rot_aeoi),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_lvl   (cmd_lvl),
    .isr_q     (isr_w),
    .base_q    (base_w)
  );

  always_comb begin
    casc_hit = is_master && fire && (win == IDX_W'(CASC_LINE));
    if (!fire)         ack_vec = {vec_base, {IDX_W{1'b1}}};
    else if (casc_hit) ack_vec = casc_vec_in;
    else               ack_vec = {vec_base, win};
    casc_ack = ack && casc_hit;
    int_out  = fire;
  end

  p_trig_lock_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    trig_wr |=> (((trig_q ^ $past(trig_q)) & ~TRIG_WMASK) == '0));

  p_win_pending_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    int_out |-> (irr_w[win] && !imr_q[win]));

  p_spur_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack && !int_out && !cmd_valid) |=> ($stable(isr_w) && $stable(base_w)));

  p_casc_isr_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (casc_ack && !auto_eoi) |=> isr_w[CASC_LINE]);
endmodule

// File: tb/tb_irq_resolver.sv
`timescale 1ns/1ps
module tb_irq_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       trig_wr = 1'b0;
  logic [7:0] trig_wdata = '0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic [4:0] vec_base = 5'h08;
  logic       is_master = 1'b0, auto_eoi = 1'b0, rot_aeoi = 1'b0;
  logic       special_mask = 1'b0, fully_nested = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0, cmd_lvl = '0;
  logic       ack = 1'b0;
  logic [7:0] casc_vec_in = 8'h99;
  logic [7:0] ack_vec;
  logic       int_out, casc_ack;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_resolver #(.TRIG_WMASK(8'hF0)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .trig_wr(trig_wr), .trig_wdata(trig_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .vec_base(vec_base), .is_master(is_master), .auto_eoi(auto_eoi),
    .rot_aeoi(rot_aeoi), .special_mask(special_mask), .fully_nested(fully_nested),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_lvl(cmd_lvl),
    .ack(ack), .casc_vec_in(casc_vec_in),
    .ack_vec(ack_vec), .int_out(int_out), .casc_ack(casc_ack)
  );

  localparam logic [3:0] S_NONE = 4'd0, S_IMR = 4'd1, S_TRIG = 4'd2,
                         S_CTL  = 4'd3, S_CMD = 4'd4, S_ACK  = 4'd5;
  // Entry: {req tag, irq_in, step, a, b, expected int_out after the step}
  // CTL a: [0] auto-EOI, [1] rotate on auto-EOI, [2] special mask, [3] fully nested, [4] master
  // CMD a: command code, b: line.  ACK a[0]: expected casc_ack, b: expected vector.
  localparam int NSTEP = 58;
  localparam logic [32:0] PLAN [NSTEP] = '{
    {4'd7,  8'h00, S_ACK,  8'h00, 8'h47, 1'b0}, // R7 spurious vector
    {4'd7,  8'h80, S_NONE, 8'h00, 8'h00, 1'b1}, // R7 no in-service bit left behind
    {4'd6,  8'h80, S_ACK,  8'h00, 8'h47, 1'b0}, // R6
    {4'd9,  8'h80, S_CMD,  8'h03, 8'h07, 1'b0}, // R9 specific EOI
    {4'd2,  8'h08, S_NONE, 8'h00, 8'h00, 1'b1}, // R2 edge on line 3
    {4'd6,  8'h08, S_ACK,  8'h00, 8'h43, 1'b0}, // R6
    {4'd5,  8'h0A, S_NONE, 8'h00, 8'h00, 1'b1}, // R5 line 1 beats line 3
    {4'd6,  8'h0A, S_ACK,  8'h00, 8'h41, 1'b0}, // R6
    {4'd5,  8'h2A, S_NONE, 8'h00, 8'h00, 1'b0}, // R5 line 5 does not beat
    {4'd9,  8'h2A, S_CMD,  8'h01, 8'h00, 1'b0}, // R9 clears line 1
    {4'd9,  8'h2A, S_CMD,  8'h01, 8'h00, 1'b1}, // R9 clears line 3
    {4'd6,  8'h2A, S_ACK,  8'h00, 8'h45, 1'b0}, // R6
    {4'd9,  8'h2A, S_CMD,  8'h03, 8'h05, 1'b0}, // R9
    {4'd5,  8'h2A, S_IMR,  8'h40, 8'h00, 1'b0}, // R5 mask line 6
    {4'd5,  8'h6A, S_NONE, 8'h00, 8'h00, 1'b0}, // R5 masked request
    {4'd5,  8'h6A, S_IMR,  8'h00, 8'h00, 1'b1}, // R5 unmasked
    {4'd6,  8'h6A, S_ACK,  8'h00, 8'h46, 1'b0}, // R6
    {4'd9,  8'h6A, S_CMD,  8'h04, 8'h06, 1'b0}, // R9 specific rotate, base 7
    {4'd5,  8'hEB, S_NONE, 8'h00, 8'h00, 1'b1}, // R5 lines 0 and 7
    {4'd5,  8'hEB, S_ACK,  8'h00, 8'h47, 1'b0}, // R5 line 7 first
    {4'd9,  8'hEB, S_CMD,  8'h02, 8'h00, 1'b1}, // R9 rotating EOI, base 0
    {4'd9,  8'hEB, S_ACK,  8'h00, 8'h40, 1'b0}, // R9
    {4'd9,  8'hEB, S_CMD,  8'h03, 8'h00, 1'b0}, // R9
    {4'd9,  8'h00, S_CMD,  8'h05, 8'h03, 1'b0}, // R9 set priority, base 4
    {4'd5,  8'h24, S_NONE, 8'h00, 8'h00, 1'b1}, // R5
    {4'd5,  8'h24, S_ACK,  8'h00, 8'h45, 1'b0}, // R5 line 5 outranks line 2
    {4'd9,  8'h24, S_CMD,  8'h03, 8'h05, 1'b1}, // R9
    {4'd5,  8'h24, S_ACK,  8'h00, 8'h42, 1'b0}, // R5
    {4'd9,  8'h24, S_CMD,  8'h03, 8'h02, 1'b0}, // R9
    {4'd9,  8'h00, S_CMD,  8'h05, 8'h07, 1'b0}, // R9 base 0
    {4'd4,  8'h00, S_TRIG, 8'hFF, 8'h00, 1'b0}, // R4 only lines 4-7 become level
    {4'd3,  8'h10, S_NONE, 8'h00, 8'h00, 1'b1}, // R3 level line 4
    {4'd3,  8'h10, S_ACK,  8'h00, 8'h44, 1'b0}, // R3
    {4'd3,  8'h10, S_CMD,  8'h03, 8'h04, 1'b1}, // R3 request survives ack
    {4'd3,  8'h00, S_NONE, 8'h00, 8'h00, 1'b0}, // R3 follows the low level
    {4'd4,  8'h02, S_NONE, 8'h00, 8'h00, 1'b1}, // R4
    {4'd4,  8'h02, S_ACK,  8'h00, 8'h41, 1'b0}, // R4
    {4'd4,  8'h02, S_CMD,  8'h03, 8'h01, 1'b0}, // R4 line 1 stayed edge
    {4'd4,  8'h00, S_TRIG, 8'h00, 8'h00, 1'b0}, // R4
    {4'd8,  8'h00, S_CTL,  8'h01, 8'h00, 1'b0}, // R8 auto-EOI
    {4'd8,  8'h08, S_NONE, 8'h00, 8'h00, 1'b1}, // R8
    {4'd8,  8'h08, S_ACK,  8'h00, 8'h43, 1'b0}, // R8
    {4'd8,  8'h48, S_NONE, 8'h00, 8'h00, 1'b1}, // R8 no in-service bit for line 3
    {4'd8,  8'h48, S_ACK,  8'h00, 8'h46, 1'b0}, // R8
    {4'd8,  8'h48, S_CTL,  8'h03, 8'h00, 1'b0}, // R8 rotate on auto-EOI
    {4'd8,  8'h4C, S_NONE, 8'h00, 8'h00, 1'b1}, // R8
    {4'd8,  8'h4C, S_ACK,  8'h00, 8'h42, 1'b0}, // R8 base 3
    {4'd8,  8'h5E, S_NONE, 8'h00, 8'h00, 1'b1}, // R8
    {4'd8,  8'h5E, S_ACK,  8'h00, 8'h44, 1'b1}, // R8 line 4 before line 1, base 5
    {4'd8,  8'h5E, S_ACK,  8'h00, 8'h41, 1'b0}, // R8
    {4'd9,  8'h00, S_CTL,  8'h00, 8'h00, 1'b0}, // R9
    {4'd9,  8'h00, S_CMD,  8'h05, 8'h07, 1'b0}, // R9 base 0
    {4'd10, 8'h20, S_NONE, 8'h00, 8'h00, 1'b1}, // R10
    {4'd10, 8'h20, S_ACK,  8'h00, 8'h45, 1'b0}, // R10
    {4'd10, 8'h60, S_NONE, 8'h00, 8'h00, 1'b0}, // R10 line 6 below line 5
    {4'd10, 8'h60, S_CTL,  8'h04, 8'h00, 1'b0}, // R10 special mask alone
    {4'd10, 8'h60, S_IMR,  8'h20, 8'h00, 1'b1}, // R10 masked in-service ignored
    {4'd10, 8'h60, S_ACK,  8'h00, 8'h46, 1'b0}  // R10
  };

  task automatic check(input int tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic set_ctl(input logic [7:0] c);
    auto_eoi     = c[0];
    rot_aeoi     = c[1];
    special_mask = c[2];
    fully_nested = c[3];
    is_master    = c[4];
  endtask

  task automatic run_step(input logic [32:0] e);
    int         tg;
    logic [3:0] op;
    logic [7:0] a, b;
    tg = int'(e[32:29]);
    op = e[20:17];
    a  = e[16:9];
    b  = e[8:1];
    @(negedge clk);
    irq_in = e[28:21];
    case (op)
      S_IMR:  begin mask_wr = 1'b1; mask_wdata = a; end
      S_TRIG: begin trig_wr = 1'b1; trig_wdata = a; end
      S_CTL:  set_ctl(a);
      S_CMD:  begin cmd_valid = 1'b1; cmd_op = a[2:0]; cmd_lvl = b[2:0]; end
      S_ACK:  ack = 1'b1;
      default: ;
    endcase
    if (op == S_ACK) begin
      #1;
      check(tg, "ack_vec", ack_vec, b);
      check(tg, "casc_ack", {7'b0, casc_ack}, {7'b0, a[0]});
    end
    @(negedge clk);
    ack = 1'b0; cmd_valid = 1'b0; mask_wr = 1'b0; trig_wr = 1'b0;
    check(tg, "int_out", {7'b0, int_out}, {7'b0, e[0]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, "int_out in reset", {7'b0, int_out}, 8'h00);  // R1
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state after the first reset
    check(1, "int_out after reset", {7'b0, int_out}, 8'h00);
    check(1, "casc_ack after reset", {7'b0, casc_ack}, 8'h00);

    for (int i = 0; i < NSTEP; i++) run_step(PLAN[i]);

    // R1: reset in the middle of operation (line 5 masked and in service)
    set_ctl(8'h00);
    irq_in = 8'h00;
    do_reset();
    check(1, "int_out after second reset", {7'b0, int_out}, 8'h00);
    run_step({4'd1, 8'h20, S_NONE, 8'h00, 8'h00, 1'b1});  // R1 mask and in-service cleared
    run_step({4'd1, 8'h20, S_ACK,  8'h00, 8'h45, 1'b0});  // R1 base back at 0

    // R12 / R11: cascade forwarding and fully nested rule on a master
    run_step({4'd12, 8'h20, S_CTL,  8'h10, 8'h00, 1'b0});
    run_step({4'd12, 8'h24, S_NONE, 8'h00, 8'h00, 1'b1});
    run_step({4'd12, 8'h24, S_ACK,  8'h01, 8'h99, 1'b0});  // R12 vector from cascade
    run_step({4'd11, 8'h20, S_NONE, 8'h00, 8'h00, 1'b0});
    run_step({4'd11, 8'h24, S_NONE, 8'h00, 8'h00, 1'b0});  // R11 blocked by in-service 2
    run_step({4'd11, 8'h24, S_CTL,  8'h18, 8'h00, 1'b1});  // R11 in-service 2 ignored
    run_step({4'd12, 8'h24, S_ACK,  8'h01, 8'h99, 1'b0});  // R12

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule